// File: doc/BRIEF.md
# Vector step query and control unit

This unit carries out one vector-stepping instruction per clock against a small held vector state. Each instruction supplies a 4-bit selector, a step-enable bit and a record bit. The selector picks one of three actions. It can read back one of four remap shape offsets supplied from outside. It can read back one of the four loop counters (source step, destination step, source sub-step, destination sub-step) supplied by a separate element step iterator. It can also write the pack and unpack mode bits that the unit holds.

When the selector asks for an explicit step and stepping is enabled, the unit sends a one-cycle advance pulse to the element step iterator, which moves its counters. With the record bit set, the unit also captures a 4-bit condition field built from the iterator's loop end-point flags. All results are registered and appear one cycle after the instruction is accepted.

Top module: `vstep_unit`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `out_valid`, `adv`, `cond_wr`, `pack` and `unpack` become 0, and `result` and `cond` become all zeros.
- R2: `in_ready` is always 1. An instruction accepted on a clock edge raises `out_valid` for exactly the following cycle. In any cycle after an edge with no accepted instruction, `out_valid` is 0 and `result` is 0.
- R3: A selector whose two top bits are both 1 (12 to 15) sets `pack` to selector bit 1 and `unpack` to selector bit 0. The result is `{pack, unpack}` in result bits 1:0. So 12 clears both, 13 gives unpack only, 14 gives pack only, and 15 sets both.
- R4: Selectors 1, 2, 3 and 4 return `shape0`, `shape1`, `shape2` and `shape3` respectively.
- R5: Selectors 5, 6, 7 and 8 return `src_step`, `dst_step`, `src_sub` and `dst_sub` respectively.
- R6: Selector 0 returns 0. With `step_en`=1 it raises `adv` for exactly the output cycle. With `step_en`=0 it raises no `adv`. No other selector ever raises `adv`.
- R7: Result bits 63 down to 7 are always 0.
- R8: An accepted instruction with `rec_en`=1 pulses `cond_wr` and loads `cond` with bit 0 = `end_inner`, bit 1 = `end_mid`, bit 2 = `end_outer` and bit 3 = `end_all`, sampled at acceptance. With `rec_en`=0, `cond_wr` stays 0 and `cond` keeps its value.
- R9: Reserved selectors 9, 10 and 11 return 0, raise no `adv`, and leave `pack` and `unpack` unchanged.
- R10: Selectors 0 to 8 leave `pack` and `unpack` unchanged.
- R11: Selector 0 with `step_en`=0 and `rec_en`=0 acts as a no-operation. The result is 0, no `adv` is raised, `cond` is unchanged and the mode bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| sel | input | 4 | Action selector |
| step_en | input | 1 | Allow the explicit step to advance the counters |
| rec_en | input | 1 | Record the condition field |
| shape0 | input | 7 | Current offset of remap shape 0 |
| shape1 | input | 7 | Current offset of remap shape 1 |
| shape2 | input | 7 | Current offset of remap shape 2 |
| shape3 | input | 7 | Current offset of remap shape 3 |
| src_step | input | 7 | Source element counter |
| dst_step | input | 7 | Destination element counter |
| src_sub | input | 2 | Source sub-element counter |
| dst_sub | input | 2 | Destination sub-element counter |
| end_inner | input | 1 | Innermost loop is at its end |
| end_mid | input | 1 | Second loop is at its end |
| end_outer | input | 1 | Outermost loop is at its end |
| end_all | input | 1 | Final element, where every loop is at its extent |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Zero-extended result |
| adv | output | 1 | One-cycle advance request to the element step iterator |
| cond_wr | output | 1 | Condition field written |
| cond | output | 4 | Condition field {final, outer, mid, inner} |
| pack | output | 1 | Pack mode bit |
| unpack | output | 1 | Unpack mode bit |

## Verification
Every selector value is driven with every combination of step-enable and record bit, back to back. This separates the read paths from one another, because each shape and counter input carries a different random value. It also shows that only selector 0 with stepping enabled produces an advance. Runs with idle gaps show that results appear only for accepted instructions. Mode writes followed by reads and reserved selectors show that the mode bits change only under the 12 to 15 selectors. Instructions issued without the record bit show that the condition field holds its previous value.

// File: rtl/vstep_unit.sv
module vstep_unit #(
  parameter int XLEN   = 64,
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        sel,
  input  logic              step_en,
  input  logic              rec_en,
  input  logic [STEP_W-1:0] shape0,
  input  logic [STEP_W-1:0] shape1,
  input  logic [STEP_W-1:0] shape2,
  input  logic [STEP_W-1:0] shape3,
  input  logic [STEP_W-1:0] src_step,
  input  logic [STEP_W-1:0] dst_step,
  input  logic [SUB_W-1:0]  src_sub,
  input  logic [SUB_W-1:0]  dst_sub,
  input  logic              end_inner,
  input  logic              end_mid,
  input  logic              end_outer,
  input  logic              end_all,
  output logic              out_valid,
  output logic [XLEN-1:0]   result,
  output logic              adv,
  output logic              cond_wr,
  output logic [3:0]        cond,
  output logic              pack,
  output logic              unpack
);

  logic            fire;
  logic            is_mode;
  logic [XLEN-1:0] nxt_res;

  assign in_ready = 1'b1;
  assign fire     = in_valid && in_ready;
  assign is_mode  = (sel[3:2] == 2'b11);

  always_comb begin
    nxt_res = '0;
    case (sel)
      4'd1:    nxt_res = XLEN'(shape0);
      4'd2:    nxt_res = XLEN'(shape1);
      4'd3:    nxt_res = XLEN'(shape2);
      4'd4:    nxt_res = XLEN'(shape3);
      4'd5:    nxt_res = XLEN'(src_step);
      4'd6:    nxt_res = XLEN'(dst_step);
      4'd7:    nxt_res = XLEN'(src_sub);
      4'd8:    nxt_res = XLEN'(dst_sub);
      default: nxt_res = is_mode ? XLEN'(sel[1:0]) : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      adv       <= 1'b0;
      cond_wr   <= 1'b0;
      cond      <= '0;
      pack      <= 1'b0;
      unpack    <= 1'b0;
    end else begin
      out_valid <= fire;
      result    <= fire ? nxt_res : '0;
      adv       <= fire && (sel == 4'd0) && step_en;
      cond_wr   <= fire && rec_en;
      if (fire && rec_en)
        cond <= {end_all, end_outer, end_mid, end_inner};
      if (fire && is_mode) begin
        pack   <= sel[1];
        unpack <= sel[0];
      end
    end
  end

  assert_out_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_idle_result_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (result == '0));

  assert_adv_with_zero_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (out_valid && result == '0));

  assert_upper_bits_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result[XLEN-1:STEP_W] == '0);

  assert_cond_write_in_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cond_wr |-> out_valid);

  assert_cond_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && rec_en) |=> $stable(cond));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && is_mode) |=> $stable({pack, unpack}));

endmodule

// File: tb/vstep_unit_test.sv
module vstep_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, step_en = 1'b0, rec_en = 1'b0;
  logic [3:0] sel = 4'd0;
  logic [6:0] shape0 = 0, shape1 = 0, shape2 = 0, shape3 = 0, src_step = 0, dst_step = 0;
  logic [1:0] src_sub = 0, dst_sub = 0;
  logic end_inner = 0, end_mid = 0, end_outer = 0, end_all = 0;
  logic in_ready, out_valid, adv, cond_wr, pack, unpack;
  logic [63:0] result;
  logic [3:0] cond;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vstep_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .sel(sel), .step_en(step_en), .rec_en(rec_en),
    .shape0(shape0), .shape1(shape1), .shape2(shape2), .shape3(shape3),
    .src_step(src_step), .dst_step(dst_step), .src_sub(src_sub), .dst_sub(dst_sub),
    .end_inner(end_inner), .end_mid(end_mid), .end_outer(end_outer), .end_all(end_all),
    .out_valid(out_valid), .result(result), .adv(adv), .cond_wr(cond_wr),
    .cond(cond), .pack(pack), .unpack(unpack));

  // behavioural reference
  logic        e_valid = 0, e_adv = 0, e_cwr = 0, e_pack = 0, e_unpack = 0;
  logic [63:0] e_res = 0;
  logic [3:0]  e_cond = 0;
  string       e_rtag = "R2", e_mtag = "R10";

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= 0; e_adv <= 0; e_cwr <= 0; e_res <= 0;
      e_cond <= 0; e_pack <= 0; e_unpack <= 0;
      e_rtag <= "R2"; e_mtag <= "R10";
    end else begin
      e_valid <= in_valid;
      e_adv   <= 0;
      e_cwr   <= 0;
      e_res   <= 0;
      e_rtag  <= "R2";
      e_mtag  <= "R10";
      if (in_valid) begin
        int s;
        s = sel;
        if (rec_en) begin
          e_cwr  <= 1;
          e_cond <= {end_all, end_outer, end_mid, end_inner};
        end
        if (s == 0) begin
          e_adv  <= step_en;
          e_rtag <= (!step_en && !rec_en) ? "R11" : "R6";
          e_mtag <= (!step_en && !rec_en) ? "R11" : "R10";
        end else if (s >= 1 && s <= 4) begin
          e_rtag <= "R4";
          e_res  <= (s == 1) ? shape0 : (s == 2) ? shape1 : (s == 3) ? shape2 : shape3;
        end else if (s >= 5 && s <= 8) begin
          e_rtag <= "R5";
          e_res  <= (s == 5) ? src_step : (s == 6) ? dst_step : (s == 7) ? src_sub : dst_sub;
        end else if (s >= 9 && s <= 11) begin
          e_rtag <= "R9";
          e_mtag <= "R9";
        end else begin
          e_rtag   <= "R3";
          e_mtag   <= "R3";
          e_pack   <= s[1];
          e_unpack <= s[0];
          e_res    <= s % 4;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      if ($time > 10) begin
        chk(out_valid == 0 && adv == 0 && cond_wr == 0, "R1", "ctl", {out_valid, adv, cond_wr}, 0);
        chk(result == 0 && cond == 0 && pack == 0 && unpack == 0, "R1", "state",
            {result[59:0], cond}, 0);
      end
    end else if (!done) begin
      chk(in_ready == 1, "R2", "in_ready", in_ready, 1);
      chk(out_valid == e_valid, "R2", "out_valid", out_valid, e_valid);
      chk(result == e_res, e_rtag, "result", result, e_res);
      chk(result[63:7] == 0, "R7", "upper", result, e_res);
      chk(adv == e_adv, (e_rtag == "R11" || e_rtag == "R9") ? e_rtag : "R6", "adv", adv, e_adv);
      chk(cond_wr == e_cwr, "R8", "cond_wr", cond_wr, e_cwr);
      chk(cond == e_cond, (e_rtag == "R11") ? "R11" : "R8", "cond", cond, e_cond);
      chk({pack, unpack} == {e_pack, e_unpack}, e_mtag, "mode", {pack, unpack}, {e_pack, e_unpack});
    end
  end

  task automatic issue(input int s, input bit vf, input bit rc);
    @(negedge clk);
    in_valid = 1; sel = 4'(s); step_en = vf; rec_en = rc;
    shape0 = 7'($urandom); shape1 = 7'($urandom); shape2 = 7'($urandom); shape3 = 7'($urandom);
    src_step = 7'($urandom); dst_step = 7'($urandom);
    src_sub = 2'($urandom); dst_sub = 2'($urandom);
    {end_all, end_outer, end_mid, end_inner} = 4'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; sel = 4'($urandom); step_en = 1; rec_en = 1;
      {end_all, end_outer, end_mid, end_inner} = 4'($urandom);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 4; m++)
        issue(s, m[0], m[1]);
    idle(3);
    issue(14, 0, 0); issue(5, 1, 0); issue(9, 1, 1); issue(0, 1, 0);
    idle(2);
    issue(13, 0, 1); issue(10, 0, 0); issue(0, 0, 0); issue(11, 1, 0);
    issue(15, 0, 0); idle(1); issue(12, 0, 0); issue(7, 0, 1);
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 5 == 0) idle(1);
      issue(int'($urandom % 16), 1'($urandom), 1'($urandom));
    end
    idle(3);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end
endmodule